// File: doc/BRIEF.md
# Three-Bit Gray Sequencer with Mixed Storage Cells

This block steps through the eight codes of a three-bit reflected Gray sequence, one step per rising clock edge. The three state bits are each held in a different kind of storage cell. The most significant bit sits in a JK cell, the middle bit in a D cell, and the least significant bit in a toggle (T) cell. Each cell has its own minimized excitation logic, and all four excitation signals are brought out as ports so that a bench can compare them against the excitation table in every state.

The state is read as the three-bit word {A,B,C}, with A as the most significant bit. The block has no data stream, so every pin is a plain control or status pin. No valid/ready handshake applies. A synchronous active-high reset returns the sequence to its start.

Top module: `gray_mixed_counter`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, `state_o` is 3'b000 after that edge, whatever the present state.
- R2: With `rst` low, each rising edge moves `state_o` one place along the order 000, 001, 011, 010, 110, 111, 101, 100, with state_o[2] = A and state_o[0] = C.
- R3: `ja_o` equals B AND NOT C of the present state. A high J with a low K sets A at the next edge.
- R4: `ka_o` equals NOT B AND NOT C of the present state. A high K with a low J clears A at the next edge, and with J and K both low A holds.
- R5: `db_o` equals B AND NOT C when A is 1, and B OR C when A is 0. B takes this value at the next edge.
- R6: `tc_o` is 1 exactly when the present state has an even number of ones. C inverts at the next edge when it is 1 and holds when it is 0.
- R7: With `rst` low, exactly one bit of `state_o` differs between consecutive edges.
- R8: From 100, the next edge with `rst` low yields 000, and the sequence then repeats without end.
- R9: The excitation outputs are combinational functions of the present state. They are valid in the same cycle as the state, with no added latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| state_o | output | 3 | Present state {A,B,C} |
| ja_o | output | 1 | J excitation of the A cell |
| ka_o | output | 1 | K excitation of the A cell |
| db_o | output | 1 | D excitation of the B cell |
| tc_o | output | 1 | T excitation of the C cell |

## Verification
A change on `rst` shows on `state_o` after exactly one rising edge. Each step of the sequence likewise appears one edge after the previous state. The excitation outputs follow the present state in the same cycle, with no edge in between. The bench changes inputs and samples all outputs on the falling edge, so each state and its four excitation values are compared half a period after the edge that produced them. The one-edge expectation for the next state is checked as the bench moves from one table row to the next.

// File: rtl/gray_mixed_pkg.sv
package gray_mixed_pkg;
  localparam int STATE_W = 3;
  localparam int A_IDX   = 2;
  localparam int B_IDX   = 1;
  localparam int C_IDX   = 0;
  localparam logic [STATE_W-1:0] START_CODE = '0;

  typedef logic [STATE_W-1:0] gstate_t;

  typedef struct packed {
    logic ja;
    logic ka;
    logic db;
    logic tc;
  } excite_t;
endpackage

// File: rtl/gmc_jk_cell.sv
module gmc_jk_cell (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else begin
      case ({j, k})
        2'b10:   q <= 1'b1;
        2'b01:   q <= 1'b0;
        2'b11:   q <= ~q;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/gmc_d_cell.sv
module gmc_d_cell (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/gmc_t_cell.sv
module gmc_t_cell (
  input  logic clk,
  input  logic rst,
  input  logic t,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)    q <= 1'b0;
    else if (t) q <= ~q;
  end
endmodule

// File: rtl/gmc_excite.sv
module gmc_excite
  import gray_mixed_pkg::*;
(
  input  gstate_t cur,
  output excite_t exc
);
  logic a, b, c;
  always_comb begin
    a = cur[A_IDX];
    b = cur[B_IDX];
    c = cur[C_IDX];
    exc.ja = b & ~c;
    exc.ka = ~b & ~c;
    exc.db = a ? (b & ~c) : (b | c);
    exc.tc = ~(a ^ b ^ c);
  end
endmodule

// File: rtl/gray_mixed_counter.sv
module gray_mixed_counter
  import gray_mixed_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  output logic [2:0]   state_o,
  output logic         ja_o,
  output logic         ka_o,
  output logic         db_o,
  output logic         tc_o
);
  gstate_t cur;
  excite_t exc;

  gmc_excite u_exc (.cur(cur), .exc(exc));

  gmc_jk_cell u_a (.clk(clk), .rst(rst), .j(exc.ja), .k(exc.ka), .q(cur[A_IDX]));
  gmc_d_cell  u_b (.clk(clk), .rst(rst), .d(exc.db), .q(cur[B_IDX]));
  gmc_t_cell  u_c (.clk(clk), .rst(rst), .t(exc.tc), .q(cur[C_IDX]));

  assign state_o = cur;
  assign ja_o    = exc.ja;
  assign ka_o    = exc.ka;
  assign db_o    = exc.db;
  assign tc_o    = exc.tc;
endmodule

// File: rtl/gmc_checker.sv
module gmc_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] state_o,
  input logic       ja_o,
  input logic       ka_o,
  input logic       db_o,
  input logic       tc_o
);
  assert_reset_start_R1: assert property (@(posedge clk) rst |=> state_o == 3'b000);

  assert_one_bit_step_R7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $countones(state_o ^ $past(state_o)) == 1);

  assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b100) |=> state_o == 3'b000);

  assert_j_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (ja_o && !ka_o) |=> state_o[2]);

  assert_k_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (ka_o && !ja_o) |=> !state_o[2]);

  assert_jk_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!ka_o && !ja_o) |=> $stable(state_o[2]));

  assert_d_follow_R5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> state_o[1] == $past(db_o));

  assert_t_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> state_o[0] == ($past(state_o[0]) ^ $past(tc_o)));

  always_comb begin
    if (!rst && !$isunknown(state_o))
      assert_no_jk_conflict_R9: assert (!(ja_o && ka_o));
  end
endmodule

bind gray_mixed_counter gmc_checker u_gmc_chk (
  .clk(clk), .rst(rst), .state_o(state_o),
  .ja_o(ja_o), .ka_o(ka_o), .db_o(db_o), .tc_o(tc_o)
);

// File: tb/tb_gray_mixed_counter.sv
module tb_gray_mixed_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] state_o;
  logic       ja_o, ka_o, db_o, tc_o;
  int         n_checks = 0;
  int         n_errs   = 0;
  bit         done     = 1'b0;

  always #4 clk = ~clk;

  gray_mixed_counter dut (
    .clk(clk), .rst(rst), .state_o(state_o),
    .ja_o(ja_o), .ka_o(ka_o), .db_o(db_o), .tc_o(tc_o)
  );

  // row: {state[2:0], ja, ka, db, tc}, in sequence order
  localparam logic [6:0] ROWS [8] = '{
    7'b000_0101, 7'b001_0010, 7'b011_0011, 7'b010_1010,
    7'b110_1011, 7'b111_0000, 7'b101_0001, 7'b100_0100
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [2:0] prev;
    @(negedge clk);
    @(negedge clk);
    check(state_o == 3'b000, "R1 reset state", state_o, 0);
    rst = 1'b0;
    prev = state_o;
    // three laps across the table, state and excitation in each step
    for (int i = 0; i < 24; i++) begin
      logic [6:0] row;
      row = ROWS[i % 8];
      check(state_o == row[6:4], (i % 8 == 0 && i > 0) ? "R8 wrap" : "R2 order", state_o, row[6:4]);
      check(ja_o == row[3], "R3 ja", ja_o, row[3]);
      check(ka_o == row[2], "R4 ka", ka_o, row[2]);
      check(db_o == row[1], "R5 db", db_o, row[1]);
      check(tc_o == row[0], "R6 tc", tc_o, row[0]);
      if (i > 0)
        check($countones(state_o ^ prev) == 1, "R7 one bit", state_o ^ prev, 1);
      prev = state_o;
      @(negedge clk);
    end
    // R9: excitation valid in the same cycle: step to 110 and look before next edge
    for (int i = 0; i < 4; i++) @(negedge clk);
    check(state_o == 3'b110, "R2 reach 110", state_o, 3'b110);
    check({ja_o, ka_o, db_o, tc_o} == 4'b1011, "R9 same-cycle excitation", {ja_o, ka_o, db_o, tc_o}, 4'b1011);
    // R1: reset from mid-sequence
    rst = 1'b1;
    @(negedge clk);
    check(state_o == 3'b000, "R1 reset from 110", state_o, 0);
    @(negedge clk);
    check(state_o == 3'b000, "R1 reset held", state_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check(state_o == 3'b001, "R2 restart after reset", state_o, 3'b001);
    // reach 100 and confirm R8 wrap directly
    for (int i = 0; i < 6; i++) @(negedge clk);
    check(state_o == 3'b100, "R2 reach 100", state_o, 3'b100);
    @(negedge clk);
    check(state_o == 3'b000, "R8 100 to 000", state_o, 0);
    // reset asserted in state 100
    for (int i = 0; i < 7; i++) @(negedge clk);
    check(state_o == 3'b100, "R2 reach 100 again", state_o, 3'b100);
    rst = 1'b1;
    @(negedge clk);
    check(state_o == 3'b000, "R1 reset from 100", state_o, 0);
    rst = 1'b0;
    done = 1'b1;
    finish_run();
  end
endmodule